// File: doc/BRIEF.md
# Transmit Completion Status Stack

This block keeps a short queue of transmit outcomes. Each time the transmit engine finishes a frame, it raises a one-cycle event together with its error flags. The block turns that event into a status byte and appends it to the queue. The oldest byte always appears on an 8-bit read port, and the host reads it there. A host write strobe on the same port discards that byte and exposes the next one. An empty queue reads as zero, so the host sees the complete bit clear and can stop draining.

The queue is four entries deep by default. When a completion arrives while every slot is occupied, the block drops that completion. It records the loss by setting an overflow bit inside the most recently stored byte, so the host learns of it when it drains that far. A jabber or underrun completion also latches a transmitter-halted output, which stays set until a transmit reset. The transmit reset empties the queue at the same time. An interrupt-style output is high whenever the byte on the read port asks for a notification on completion.

Top module: `txs_stack_top`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `rd_data` is 0x00, `txc_irq` is 0 and `tx_halted` is 0.
- R2: A completion event stores the byte {bit7=1 complete, bit6=`ev_intreq`, bit5=`ev_jabber`, bit4=`ev_underrun`, bit3=`ev_maxcoll`, bit2=0 overflow, bits1:0=0}; bits 1:0 of `rd_data` always read 0, and a non-empty queue always presents bit 7 set.
- R3: Entries leave in arrival order, and up to DEPTH (default 4) entries are held.
- R4: A `host_wr` pulse with a non-empty queue removes the oldest entry; the next entry (or 0x00) is on `rd_data` in the following cycle.
- R5: With the queue empty, `rd_data` is 0x00, and a `host_wr` pulse changes nothing.
- R6: An event arriving while the queue holds DEPTH entries and no pop happens in that cycle is discarded. Bit 2 is set in the most recently stored entry, and the older entries are unchanged.
- R7: With the queue full, an event and a `host_wr` in the same cycle both take effect: the oldest leaves, the new entry is appended, and no overflow is marked.
- R8: An event with `ev_jabber` or `ev_underrun` set raises `tx_halted` in the next cycle, even if that event is discarded. `tx_halted` stays high until a transmit reset. `ev_maxcoll` alone never raises it.
- R9: A `tx_reset` pulse empties the queue and clears `tx_halted` in the next cycle. It overrides any event or `host_wr` in the same cycle.
- R10: `txc_irq` is 1 exactly when the queue is non-empty and bit 6 of the oldest entry is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | One-cycle transmit completion event |
| ev_intreq | input | 1 | Completion asks for a notification |
| ev_jabber | input | 1 | Completion ended by jabber |
| ev_underrun | input | 1 | Completion ended by data underrun |
| ev_maxcoll | input | 1 | Completion hit the collision limit |
| host_wr | input | 1 | Host write to the status port; pops the oldest entry |
| tx_reset | input | 1 | Transmit reset; empties queue and clears halt |
| rd_data | output | 8 | Oldest status byte, or 0x00 when empty |
| txc_irq | output | 1 | Oldest entry requests a completion notification |
| tx_halted | output | 1 | Sticky flag: transmitter needs a reset |

## Verification
The bench first fills the queue, then pushes two more events. A design that overwrote a slot, marked the oldest entry instead of the newest, or let the count wrap would show the wrong byte or a missing overflow bit during the drain. The bench also pops and pushes in the same cycle on a full queue and on a single-entry queue. A design that gave either side priority would either lose the new entry or flag an overflow that never happened. It pops an empty queue, checks that a maximum-collision event does not halt while jabber and underrun events do, and issues a transmit reset in the same cycle as an error event. A design that let the event win would leave the halt set or the queue non-empty.

// File: rtl/txs_pkg.sv
package txs_pkg;

    localparam int unsigned STAT_W = 8;

    typedef struct packed {
        logic complete;
        logic intreq;
        logic jabber;
        logic underrun;
        logic maxcoll;
        logic overflow;
    } txs_entry_t;

    typedef struct packed {
        logic       valid;
        txs_entry_t entry;
    } txs_event_t;

    function automatic logic [STAT_W-1:0] entry_to_byte(input txs_entry_t e);
        return {e.complete, e.intreq, e.jabber, e.underrun,
                e.maxcoll, e.overflow, 2'b00};
    endfunction

    function automatic logic needs_tx_reset(input txs_entry_t e);
        return e.jabber | e.underrun;
    endfunction

endpackage

// File: rtl/txs_event_encode.sv
module txs_event_encode
    import txs_pkg::*;
(
    input  logic       ev_valid,
    input  logic       ev_intreq,
    input  logic       ev_jabber,
    input  logic       ev_underrun,
    input  logic       ev_maxcoll,
    output txs_event_t evt,
    output logic       fatal
);
    always_comb begin
        evt.valid          = ev_valid;
        evt.entry.complete = 1'b1;
        evt.entry.intreq   = ev_intreq;
        evt.entry.jabber   = ev_jabber;
        evt.entry.underrun = ev_underrun;
        evt.entry.maxcoll  = ev_maxcoll;
        evt.entry.overflow = 1'b0;
        fatal              = ev_valid & needs_tx_reset(evt.entry);
    end
endmodule

// File: rtl/txs_queue.sv
module txs_queue
    import txs_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             push,
    input  txs_entry_t       push_entry,
    input  logic             pop,
    output txs_entry_t       head_entry,
    output logic             head_valid,
    output logic [CNT_W-1:0] count,
    output logic             ovf_hit
);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + PTR_W'(1);
    endfunction

    function automatic logic [PTR_W-1:0] ptr_dec(input logic [PTR_W-1:0] p);
        return (p == '0) ? LAST_IDX : p - PTR_W'(1);
    endfunction

    logic [PTR_W-1:0] rd_ptr, wr_ptr, newest_ptr;
    logic [CNT_W-1:0] cnt_r;
    logic             pop_ok, push_ok, is_full;
    txs_entry_t       slot_q [DEPTH];

    always_comb begin
        is_full    = (cnt_r == FULL_CNT);
        pop_ok     = pop && (cnt_r != '0);
        push_ok    = push && (!is_full || pop_ok);
        ovf_hit    = push && is_full && !pop_ok;
        newest_ptr = ptr_dec(wr_ptr);
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        txs_entry_t slot_r;
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                slot_r <= '0;
            end else if (push_ok && wr_ptr == PTR_W'(g)) begin
                slot_r <= push_entry;
            end else if (ovf_hit && newest_ptr == PTR_W'(g)) begin
                slot_r.overflow <= 1'b1;
            end
        end
        assign slot_q[g] = slot_r;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt_r  <= '0;
        end else begin
            if (pop_ok)  rd_ptr <= ptr_inc(rd_ptr);
            if (push_ok) wr_ptr <= ptr_inc(wr_ptr);
            case ({push_ok, pop_ok})
                2'b10:   cnt_r <= cnt_r + CNT_W'(1);
                2'b01:   cnt_r <= cnt_r - CNT_W'(1);
                default: cnt_r <= cnt_r;
            endcase
        end
    end

    assign head_valid = (cnt_r != '0);
    assign head_entry = head_valid ? slot_q[rd_ptr] : '0;
    assign count      = cnt_r;
endmodule

// File: rtl/txs_halt_track.sv
module txs_halt_track (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic set,
    output logic halted
);
    always_ff @(posedge clk) begin
        if (rst || clear) halted <= 1'b0;
        else if (set)     halted <= 1'b1;
    end
endmodule

// File: rtl/txs_stack_top.sv
module txs_stack_top
    import txs_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid,
    input  logic              ev_intreq,
    input  logic              ev_jabber,
    input  logic              ev_underrun,
    input  logic              ev_maxcoll,
    input  logic              host_wr,
    input  logic              tx_reset,
    output logic [STAT_W-1:0] rd_data,
    output logic              txc_irq,
    output logic              tx_halted
);
    txs_event_t       evt;
    logic             fatal_ev;
    txs_entry_t       head;
    logic             head_valid;
    logic [CNT_W-1:0] q_count;
    logic             q_ovf;

    txs_event_encode u_enc (
        .ev_valid    (ev_valid),
        .ev_intreq   (ev_intreq),
        .ev_jabber   (ev_jabber),
        .ev_underrun (ev_underrun),
        .ev_maxcoll  (ev_maxcoll),
        .evt         (evt),
        .fatal       (fatal_ev)
    );

    txs_queue #(.DEPTH(DEPTH)) u_q (
        .clk        (clk),
        .rst        (rst),
        .clear      (tx_reset),
        .push       (evt.valid),
        .push_entry (evt.entry),
        .pop        (host_wr),
        .head_entry (head),
        .head_valid (head_valid),
        .count      (q_count),
        .ovf_hit    (q_ovf)
    );

    txs_halt_track u_halt (
        .clk    (clk),
        .rst    (rst),
        .clear  (tx_reset),
        .set    (fatal_ev),
        .halted (tx_halted)
    );

    assign rd_data = entry_to_byte(head);
    assign txc_irq = head_valid & head.complete & head.intreq;
endmodule

// File: rtl/txs_stack_chk.sv
module txs_stack_chk #(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             ev_valid,
    input logic             ev_jabber,
    input logic             ev_underrun,
    input logic             host_wr,
    input logic             tx_reset,
    input logic [7:0]       rd_data,
    input logic             txc_irq,
    input logic             tx_halted,
    input logic [CNT_W-1:0] q_count
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_data[1:0] == 2'b00); // R2
    AST_HELD_COMPLETE: assert property (@(posedge clk) disable iff (rst)
        (q_count != '0) |-> rd_data[7]); // R2
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        q_count <= FULL_CNT); // R3
    AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (rst)
        (host_wr && q_count != '0 && !ev_valid && !tx_reset)
        |=> q_count == $past(q_count) - CNT_W'(1)); // R4
    AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (q_count == '0) |-> rd_data == 8'h00); // R5
    AST_FULL_DROPS: assert property (@(posedge clk) disable iff (rst)
        (q_count == FULL_CNT && ev_valid && !host_wr && !tx_reset)
        |=> q_count == FULL_CNT); // R6
    AST_HALT_RAISE: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && (ev_jabber || ev_underrun) && !tx_reset) |=> tx_halted); // R8
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (tx_halted && !tx_reset) |=> tx_halted); // R8
    AST_TXRESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        tx_reset |=> (q_count == '0 && !tx_halted)); // R9
    AST_IRQ_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (q_count == '0) |-> !txc_irq); // R10
endmodule

bind txs_stack_top txs_stack_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ev_valid    (ev_valid),
    .ev_jabber   (ev_jabber),
    .ev_underrun (ev_underrun),
    .host_wr     (host_wr),
    .tx_reset    (tx_reset),
    .rd_data     (rd_data),
    .txc_irq     (txc_irq),
    .tx_halted   (tx_halted),
    .q_count     (q_count)
);

// File: tb/sim_txs_stack_top.sv
module sim_txs_stack_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ev_valid = 0, ev_intreq = 0, ev_jabber = 0, ev_underrun = 0, ev_maxcoll = 0;
    logic       host_wr = 0, tx_reset = 0;
    logic [7:0] rd_data;
    logic       txc_irq, tx_halted;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    logic [7:0] exp_q[$];
    logic       exp_halt = 0;
    localparam int MDEPTH = 4;

    always #10 clk = ~clk;

    txs_stack_top u0 (
        .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_intreq(ev_intreq),
        .ev_jabber(ev_jabber), .ev_underrun(ev_underrun), .ev_maxcoll(ev_maxcoll),
        .host_wr(host_wr), .tx_reset(tx_reset), .rd_data(rd_data),
        .txc_irq(txc_irq), .tx_halted(tx_halted)
    );

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // monitor: compare the port against the scoreboard head
    task automatic monitor(input string tag);
        logic [7:0] eh;
        eh = (exp_q.size() != 0) ? exp_q[0] : 8'h00;
        chk(tag, "rd_data", rd_data, eh);
        chk(tag, "txc_irq", {7'd0, txc_irq}, {7'd0, (exp_q.size() != 0) && eh[6]});
        chk(tag, "tx_halted", {7'd0, tx_halted}, {7'd0, exp_halt});
    endtask

    // driver: apply one cycle of stimulus and update the scoreboard
    task automatic step(input string tag, input logic ev, input logic ir,
                        input logic jb, input logic ur, input logic mc,
                        input logic wr, input logic tr);
        logic full, pop_ok;
        ev_valid = ev; ev_intreq = ir; ev_jabber = jb; ev_underrun = ur;
        ev_maxcoll = mc; host_wr = wr; tx_reset = tr;
        @(posedge clk);
        if (tr) begin
            exp_q.delete();
            exp_halt = 0;
        end else begin
            full   = (exp_q.size() == MDEPTH);
            pop_ok = wr && (exp_q.size() != 0);
            if (ev && (jb || ur)) exp_halt = 1;
            if (pop_ok) void'(exp_q.pop_front());
            if (ev) begin
                if (!full || pop_ok) exp_q.push_back({1'b1, ir, jb, ur, mc, 3'b000});
                else exp_q[exp_q.size()-1] = exp_q[exp_q.size()-1] | 8'h04;
            end
        end
        @(negedge clk);
        ev_valid = 0; ev_intreq = 0; ev_jabber = 0; ev_underrun = 0;
        ev_maxcoll = 0; host_wr = 0; tx_reset = 0;
        monitor(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        monitor("R1");
        rst = 1'b0;
        @(negedge clk);
        monitor("R1");

        // R2 / R3 / R10: distinct flag patterns, then drain in order
        step("R2", 1, 1, 0, 0, 0, 0, 0);
        step("R2", 1, 0, 0, 0, 1, 0, 0);
        step("R3", 1, 1, 0, 0, 1, 0, 0);
        step("R4", 0, 0, 0, 0, 0, 1, 0);
        step("R10", 0, 0, 0, 0, 0, 1, 0);
        step("R4", 0, 0, 0, 0, 0, 1, 0);

        // R5: pop on empty
        step("R5", 0, 0, 0, 0, 0, 1, 0);
        step("R5", 0, 0, 0, 0, 0, 0, 0);

        // R6: fill, overflow twice, drain
        step("R3", 1, 0, 0, 0, 0, 0, 0);
        step("R3", 1, 1, 0, 0, 0, 0, 0);
        step("R3", 1, 0, 0, 0, 1, 0, 0);
        step("R3", 1, 0, 0, 0, 0, 0, 0);
        step("R6", 1, 1, 0, 0, 1, 0, 0);
        step("R6", 1, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 4; i++) step("R6", 0, 0, 0, 0, 0, 1, 0);

        // R7: full queue, simultaneous push and pop
        for (int i = 0; i < 4; i++) step("R7", 1, i[0], 0, 0, 0, 0, 0);
        step("R7", 1, 1, 0, 0, 1, 1, 0);
        for (int i = 0; i < 5; i++) step("R7", 0, 0, 0, 0, 0, 1, 0);

        // push and pop on a single entry
        step("R4", 1, 0, 0, 0, 0, 0, 0);
        step("R4", 1, 1, 0, 0, 0, 1, 0);
        step("R4", 0, 0, 0, 0, 0, 1, 0);

        // R8: collision limit alone, then jabber, then sticky
        step("R8", 1, 0, 0, 0, 1, 0, 0);
        step("R8", 1, 0, 1, 0, 0, 0, 0);
        step("R8", 0, 0, 0, 0, 0, 1, 0);
        step("R8", 0, 0, 0, 0, 0, 1, 0);
        step("R8", 0, 0, 0, 0, 0, 0, 0);

        // R9: transmit reset clears halt and queue
        step("R9", 1, 1, 0, 0, 0, 0, 0);
        step("R9", 0, 0, 0, 0, 0, 0, 1);

        // R8: underrun event dropped while full still halts
        for (int i = 0; i < 4; i++) step("R8", 1, 0, 0, 0, 0, 0, 0);
        step("R8", 1, 0, 0, 1, 0, 0, 0);

        // R9: reset wins over same-cycle error event and pop
        step("R9", 1, 1, 1, 1, 0, 1, 1);
        step("R9", 0, 0, 0, 0, 0, 0, 0);

        // R10: interrupt follows oldest entry
        step("R10", 1, 0, 0, 0, 0, 0, 0);
        step("R10", 1, 1, 0, 0, 0, 0, 0);
        step("R10", 0, 0, 0, 0, 0, 1, 0);
        step("R10", 0, 0, 0, 0, 0, 1, 0);

        done = 1;
        summary();
    end
endmodule